// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block produces the word address sequence for a multiple-register load or store. A caller presents a base address, a register mask of up to sixteen entries, an addressing-mode code, and the load, write-back and S flags, then pulses `start_i`. The sequencer decodes the mode code into an up/down direction and a before/after adjustment. It then issues one word transfer request for each set bit of the mask and waits for an acknowledge on each one before it moves on.

Registers always go out in ascending index order, and the lowest index always lands on the lowest address, so decrementing modes begin below the base. At the end the block pulses `done_o` and presents the updated base value with a write enable. The S flag is not acted on here. It is turned into either a status-restore request or a user-bank request for the surrounding logic to act upon.

Top module: `blk_xfer_seq`

## Requirements
- R1: For loads (`load_i`=1), `mode_i` codes 0=IA, 1=IB, 2=DA, 3=DB map directly. The stack codes map as 4=FD→IA, 5=ED→IB, 6=FA→DA and 7=EA→DB.
- R2: For stores (`load_i`=0), the plain codes 0..3 map as in R1. The stack codes map as 4=FD→DB, 5=ED→DA, 6=FA→IB and 7=EA→IA.
- R3: IA places its first transfer at base and IB places it at base+4. Each later transfer is 4 above the previous one.
- R4: With n set mask bits, DA places its lowest transfer at base−4n+4 and DB places it at base−4n. Later transfers rise by 4.
- R5: Exactly one request is issued for each set mask bit, in ascending register index, including for non-contiguous masks. `req_reg_o` carries the index and `req_load_o` carries the load flag.
- R6: A request holds its address and index stable until it is acknowledged. The next request is presented in the cycle after the acknowledge.
- R7: `done_o` is a one-cycle pulse in the cycle after the last acknowledge, with `busy_o` and `req_o` low.
- R8: `wb_val_o` is base+4n for incrementing modes and base−4n for decrementing modes. `wb_we_o` equals `wb_i` during the done pulse and is low otherwise.
- R9: An empty mask makes no request. It pulses `done_o` in the cycle after start, with `wb_val_o` equal to the base.
- R10: At done, `restore_o` = S & load & mask[15] and `user_bank_o` = S & !(load & mask[15]). The two are never high together.
- R11: A `start_i` pulse while `busy_o` is high has no effect on the running sequence.
- R12: While reset is asserted, `req_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_i | input | 32 | Base register value |
| rlist_i | input | 16 | Register mask |
| mode_i | input | 3 | Addressing-mode code (see R1, R2) |
| load_i | input | 1 | 1 = load, 0 = store |
| wb_i | input | 1 | Write-back requested |
| sbit_i | input | 1 | S flag |
| ack_i | input | 1 | Transfer acknowledge |
| busy_o | output | 1 | Sequence in progress |
| req_o | output | 1 | Transfer request |
| req_addr_o | output | 32 | Transfer word address |
| req_reg_o | output | 4 | Register index of the transfer |
| req_load_o | output | 1 | Transfer direction (1 = load) |
| done_o | output | 1 | Completion pulse |
| wb_we_o | output | 1 | Base write-back enable |
| wb_val_o | output | 32 | Updated base value |
| restore_o | output | 1 | Status-register restore request |
| user_bank_o | output | 1 | User-bank transfer request |

## Verification
The first request is registered at the start edge, so it is visible in the cycle after start. Each later request appears in the cycle after the acknowledge of the one before it. `done_o` follows the final acknowledge by exactly one cycle, and it follows start by one cycle when the mask is empty. The bench records the cycle count when it raises an acknowledge and when it raises start, then compares the cycle at which `done_o` shows against those marks. All outputs are sampled on the falling edge, and the queue of expected address/index pairs is compared against the request at the moment each acknowledge is given.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [2:0] {
    AM_IA = 3'd0,
    AM_IB = 3'd1,
    AM_DA = 3'd2,
    AM_DB = 3'd3,
    AM_FD = 3'd4,
    AM_ED = 3'd5,
    AM_FA = 3'd6,
    AM_EA = 3'd7
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_st_e;
endpackage

// File: rtl/bxs_mode_dec.sv
module bxs_mode_dec
  import bxs_pkg::*;
(
  input  amode_e mode,
  input  logic   load,
  output logic   pre,
  output logic   up
);
  // Stack codes flip with direction: a full/empty, ascending/descending
  // stack means opposite adjustments for loads and stores.
  always_comb begin
    pre = 1'b0;
    up  = 1'b1;
    unique case (mode)
      AM_IA: begin pre = 1'b0; up = 1'b1; end
      AM_IB: begin pre = 1'b1; up = 1'b1; end
      AM_DA: begin pre = 1'b0; up = 1'b0; end
      AM_DB: begin pre = 1'b1; up = 1'b0; end
      AM_FD: begin pre = !load; up = load;  end
      AM_ED: begin pre = load;  up = load;  end
      AM_FA: begin pre = !load; up = !load; end
      AM_EA: begin pre = load;  up = !load; end
      default: begin pre = 1'b0; up = 1'b1; end
    endcase
  end
endmodule

// File: rtl/bxs_addr_calc.sv
module bxs_addr_calc #(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int WB   = 4
) (
  input  logic [AW-1:0]   base,
  input  logic [NREG-1:0] mask,
  input  logic            pre,
  input  logic            up,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   wb_val
);
  localparam int CW = $clog2(NREG + 1);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;
  logic [AW-1:0] step;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) begin
      cnt = cnt + CW'(mask[i]);
    end
  end

  assign step = AW'(WB);
  assign span = AW'(cnt) * step;

  always_comb begin
    if (up) begin
      first_addr = pre ? (base + step) : base;
      wb_val     = base + span;
    end else begin
      first_addr = pre ? (base - span) : (base - span + step);
      wb_val     = base - span;
    end
  end
endmodule

// File: rtl/bxs_pick.sv
module bxs_pick #(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  output logic [IW-1:0]   idx,
  output logic            any,
  output logic [NREG-1:0] rest
);
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end

  assign any  = |mask;
  assign rest = mask & (mask - NREG'(1));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bxs_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NREG = 16,
  parameter int WB   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] rlist_i,
  input  logic [2:0]      mode_i,
  input  logic            load_i,
  input  logic            wb_i,
  input  logic            sbit_i,
  input  logic            ack_i,
  output logic            busy_o,
  output logic            req_o,
  output logic [AW-1:0]   req_addr_o,
  output logic [IW-1:0]   req_reg_o,
  output logic            req_load_o,
  output logic            done_o,
  output logic            wb_we_o,
  output logic [AW-1:0]   wb_val_o,
  output logic            restore_o,
  output logic            user_bank_o
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  // decode and address arithmetic on the start operands
  logic          pre_w, up_w;
  logic [AW-1:0] first_w, wbv_w;

  bxs_mode_dec u_dec (
    .mode (amode_e'(mode_i)),
    .load (load_i),
    .pre  (pre_w),
    .up   (up_w)
  );

  bxs_addr_calc #(.AW(AW), .NREG(NREG), .WB(WB)) u_calc (
    .base       (base_i),
    .mask       (rlist_i),
    .pre        (pre_w),
    .up         (up_w),
    .first_addr (first_w),
    .wb_val     (wbv_w)
  );

  // lowest set bit of the incoming and of the remaining mask
  logic [IW-1:0]   in_idx, rem_idx;
  logic            in_any, rem_any;
  logic [NREG-1:0] in_rest, rem_rest;
  logic [NREG-1:0] rem_q;

  bxs_pick #(.NREG(NREG), .IW(IW)) u_pick_in (
    .mask (rlist_i), .idx (in_idx), .any (in_any), .rest (in_rest)
  );

  bxs_pick #(.NREG(NREG), .IW(IW)) u_pick_rem (
    .mask (rem_q), .idx (rem_idx), .any (rem_any), .rest (rem_rest)
  );

  // state
  seq_st_e         st_q, st_n;
  logic [NREG-1:0] rem_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [IW-1:0]   reg_q, reg_n;
  logic            load_q, wbreq_q;
  logic [AW-1:0]   wbv_q;
  logic            rest_q, user_q;
  logic            done_q, done_n, we_q, we_n;
  logic            cap_en, adv_en, step_en;

  assign cap_en  = (st_q == ST_IDLE) && start_i;
  assign adv_en  = (st_q == ST_XFER) && ack_i;
  assign step_en = cap_en || adv_en;

  always_comb begin
    st_n   = st_q;
    rem_n  = rem_q;
    addr_n = addr_q;
    reg_n  = reg_q;
    done_n = 1'b0;
    we_n   = 1'b0;
    if (cap_en) begin
      if (in_any) begin
        st_n   = ST_XFER;
        rem_n  = in_rest;
        addr_n = first_w;
        reg_n  = in_idx;
      end else begin
        done_n = 1'b1;
        we_n   = wb_i;
      end
    end else if (adv_en) begin
      if (rem_any) begin
        rem_n  = rem_rest;
        addr_n = addr_q + AW'(WB);
        reg_n  = rem_idx;
      end else begin
        st_n   = ST_IDLE;
        done_n = 1'b1;
        we_n   = wbreq_q;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      we_q   <= we_n;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rem_q  <= '0;
      addr_q <= '0;
      reg_q  <= '0;
    end else if (step_en) begin
      rem_q  <= rem_n;
      addr_q <= addr_n;
      reg_q  <= reg_n;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      load_q  <= 1'b0;
      wbreq_q <= 1'b0;
      wbv_q   <= '0;
      rest_q  <= 1'b0;
      user_q  <= 1'b0;
    end else if (cap_en) begin
      load_q  <= load_i;
      wbreq_q <= wb_i;
      wbv_q   <= wbv_w;
      rest_q  <= sbit_i && load_i && rlist_i[NREG-1];
      user_q  <= sbit_i && !(load_i && rlist_i[NREG-1]);
    end
  end

  assign busy_o      = (st_q == ST_XFER);
  assign req_o       = busy_o;
  assign req_addr_o  = addr_q;
  assign req_reg_o   = reg_q;
  assign req_load_o  = load_q;
  assign done_o      = done_q;
  assign wb_we_o     = we_q;
  assign wb_val_o    = wbv_q;
  assign restore_o   = rest_q;
  assign user_bank_o = user_q;
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
  parameter int AW = 32,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          ack_i,
  input logic          busy_o,
  input logic          req_o,
  input logic [AW-1:0] req_addr_o,
  input logic [IW-1:0] req_reg_o,
  input logic          done_o,
  input logic          wb_we_o,
  input logic          restore_o,
  input logic          user_bank_o
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(req_addr_o) && $stable(req_reg_o))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (!req_o || (req_addr_o == $past(req_addr_o) + AW'(4)))); // R3
  AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack_i) |=> (!req_o || (req_reg_o > $past(req_reg_o)))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!req_o && !busy_o)); // R7
  AST_WE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we_o |-> done_o); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(restore_o && user_bank_o)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ack_i) |=> $stable(req_addr_o)); // R11
endmodule

bind blk_xfer_seq bxs_chk #(.AW(AW), .IW(IW)) u_bxs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ack_i       (ack_i),
  .busy_o      (busy_o),
  .req_o       (req_o),
  .req_addr_o  (req_addr_o),
  .req_reg_o   (req_reg_o),
  .done_o      (done_o),
  .wb_we_o     (wb_we_o),
  .restore_o   (restore_o),
  .user_bank_o (user_bank_o)
);

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] rlist_i = '0;
  logic [2:0]  mode_i = '0;
  logic        load_i = 1'b0, wb_i = 1'b0, sbit_i = 1'b0, ack_i = 1'b0;
  logic        busy_o, req_o, req_load_o, done_o, wb_we_o, restore_o, user_bank_o;
  logic [31:0] req_addr_o, wb_val_o;
  logic [3:0]  req_reg_o;

  always #4 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .rlist_i(rlist_i), .mode_i(mode_i), .load_i(load_i), .wb_i(wb_i),
    .sbit_i(sbit_i), .ack_i(ack_i), .busy_o(busy_o), .req_o(req_o),
    .req_addr_o(req_addr_o), .req_reg_o(req_reg_o), .req_load_o(req_load_o),
    .done_o(done_o), .wb_we_o(wb_we_o), .wb_val_o(wb_val_o),
    .restore_o(restore_o), .user_bank_o(user_bank_o)
  );

  typedef struct { logic [31:0] a; logic [3:0] r; } item_t;
  item_t exp_q[$];

  int    checks = 0, fails = 0;
  int    cyc = 0, last_ack_cyc = 0, stall_n = 0, stall_cnt = 0;
  bit    cur_ld = 1'b0;
  string cur_tag = "R5";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  // monitor: acknowledges requests and compares them with the scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      ack_i <= 1'b0;
      stall_cnt = 0;
    end else if (req_o) begin
      if (stall_cnt < stall_n) begin
        stall_cnt++;
        ack_i <= 1'b0;
      end else begin
        stall_cnt = 0;
        ack_i <= 1'b1;
        last_ack_cyc = cyc;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected request addr", req_addr_o, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(req_addr_o == it.a, cur_tag, "request address", req_addr_o, it.a);
          chk(req_reg_o == it.r, "R5", "request register", {28'h0, req_reg_o}, {28'h0, it.r});
          chk(req_load_o == cur_ld, "R5", "request load flag", {31'h0, req_load_o}, {31'h0, cur_ld});
        end
      end
    end else begin
      ack_i <= 1'b0;
    end
  end

  function automatic void exp_pu(input logic [2:0] m, input bit ld, output bit p, output bit u);
    case (m)
      3'd0: begin p = 0; u = 1; end
      3'd1: begin p = 1; u = 1; end
      3'd2: begin p = 0; u = 0; end
      3'd3: begin p = 1; u = 0; end
      3'd4: begin p = ld ? 0 : 1; u = ld ? 1 : 0; end // FD
      3'd5: begin p = ld ? 1 : 0; u = ld ? 1 : 0; end // ED
      3'd6: begin p = ld ? 0 : 1; u = ld ? 0 : 1; end // FA
      default: begin p = ld ? 1 : 0; u = ld ? 0 : 1; end // EA
    endcase
  endfunction

  task automatic run(input logic [31:0] base, input logic [15:0] rl, input logic [2:0] m,
                     input bit ld, input bit w, input bit s, input int stall,
                     input bit poke, input string tag);
    bit p, u;
    int n, k, c;
    logic [31:0] low, wbv;
    exp_pu(m, ld, p, u);
    n = $countones(rl);
    if (u) begin
      low = p ? base + 32'd4 : base;
      wbv = base + 32'(4 * n);
    end else begin
      low = p ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
      wbv = base - 32'(4 * n);
    end
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (rl[i]) begin
        exp_q.push_back('{a: low + 32'(4 * k), r: 4'(i)});
        k++;
      end
    end
    cur_tag = tag;
    cur_ld  = ld;
    stall_n = stall;
    base_i = base; rlist_i = rl; mode_i = m; load_i = ld; wb_i = w; sbit_i = s;
    start_i = 1'b1;
    c = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R11: a second start during the sequence must change nothing
      @(negedge clk);
      base_i = base ^ 32'h00F0_0000; rlist_i = ~rl; mode_i = m ^ 3'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (n == 0)
      chk(cyc == c + 1, "R9", "done cycle after start", 32'(cyc), 32'(c + 1));
    else
      chk(cyc == last_ack_cyc + 1, "R7", "done cycle after last ack", 32'(cyc), 32'(last_ack_cyc + 1));
    chk(!busy_o && !req_o, "R7", "busy/req at done", {30'h0, busy_o, req_o}, 32'h0);
    chk(exp_q.size() == 0, (n == 0) ? "R9" : "R5", "transfers left", 32'(exp_q.size()), 32'h0);
    chk(wb_val_o == wbv, (n == 0) ? "R9" : "R8", "write-back value", wb_val_o, wbv);
    chk(wb_we_o == w, "R8", "write-back enable", {31'h0, wb_we_o}, {31'h0, w});
    chk(restore_o == (s && ld && rl[15]), "R10", "restore flag",
        {31'h0, restore_o}, {31'h0, (s && ld && rl[15])});
    chk(user_bank_o == (s && !(ld && rl[15])), "R10", "user-bank flag",
        {31'h0, user_bank_o}, {31'h0, (s && !(ld && rl[15]))});
    @(negedge clk);
    chk(!done_o && !wb_we_o, "R7", "done pulse width", {30'h0, done_o, wb_we_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_o && !busy_o && !done_o, "R12", "outputs in reset", {29'h0, req_o, busy_o, done_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: load decodes, plain and stack
    run(32'h0000_1000, 16'h00F1, 3'd0, 1, 1, 0, 0, 0, "R3");
    run(32'h0000_2000, 16'h0306, 3'd5, 1, 1, 0, 1, 0, "R1");
    run(32'h0000_3000, 16'h0051, 3'd6, 1, 1, 0, 0, 0, "R1");
    run(32'h0000_4000, 16'h1111, 3'd7, 1, 0, 0, 2, 0, "R1");
    run(32'h0000_4800, 16'h0003, 3'd4, 1, 1, 0, 0, 0, "R1");
    // R2: store decodes, stack names
    run(32'h0000_5000, 16'h00C0, 3'd6, 0, 1, 0, 0, 0, "R2");
    run(32'h0000_6000, 16'h0C01, 3'd7, 0, 1, 0, 0, 0, "R2");
    run(32'h0000_7000, 16'h4001, 3'd4, 0, 1, 0, 1, 0, "R2");
    run(32'h0000_8000, 16'h0870, 3'd5, 0, 1, 0, 0, 0, "R2");
    // R3/R4: plain modes on stores
    run(32'h0000_9000, 16'h0005, 3'd1, 0, 1, 0, 0, 0, "R3");
    run(32'h0000_A000, 16'h0018, 3'd2, 0, 0, 0, 0, 0, "R4");
    run(32'h0000_B000, 16'hFFFF, 3'd3, 1, 1, 0, 3, 0, "R4");
    // R10: S flag variants
    run(32'h0001_0000, 16'h8421, 3'd0, 1, 1, 1, 0, 0, "R10");
    run(32'h0001_1000, 16'h8421, 3'd0, 0, 1, 1, 0, 0, "R10");
    run(32'h0001_2000, 16'h0421, 3'd1, 1, 0, 1, 0, 0, "R10");
    // R9: empty list, R8: no write-back
    run(32'h0002_0000, 16'h0000, 3'd3, 1, 1, 0, 0, 0, "R9");
    run(32'h0002_1000, 16'h0000, 3'd2, 0, 0, 1, 0, 0, "R9");
    // R11: start while busy
    run(32'h0003_0000, 16'h0F00, 3'd0, 0, 1, 0, 2, 1, "R11");
    // R12: reset in mid-sequence
    run_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic run_reset_mid();
    stall_n = 50;
    base_i = 32'h0004_0000; rlist_i = 16'h00FF; mode_i = 3'd0; load_i = 1; wb_i = 1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(req_o, "R12", "request before reset", {31'h0, req_o}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!req_o && !busy_o && !done_o, "R12", "outputs after reset", {29'h0, req_o, busy_o, done_o}, 32'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule